// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the bus-facing half of a small nonvolatile byte memory that answers as a slave on a two-wire I2C bus. It runs on a fast internal clock. That clock oversamples the serial clock and data lines through two-flop synchronizers and finds START and STOP conditions and clock edges in the sampled stream. SDA is driven only through an open-drain pull-down enable. The block answers to one fixed 7-bit device code. Write commands carry a two-byte memory address and then one or more data bytes, which are collected into a page buffer. Read commands return bytes from the address pointer, which steps forward after each byte.

A STOP that ends a write with at least one accepted data byte starts a timed programming interval. During that interval the buffered page is copied into the internal array. For the whole interval the block neither watches nor drives the bus. A hardware write-lock input makes the block decline data bytes while it still accepts the device code and address bytes. This lets a locked part still serve random reads.

The address is ADDR_W bits wide (11 by default, a 2 KiB array, to keep elaboration small). The high address byte carries the upper ADDR_W-8 bits in its low-order positions, and its other bits are ignored. Pages hold PAGE_BYTES bytes (32 by default).

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After a START the first byte is taken MSB first as a 7-bit device code followed by a direction bit (1 = read, 0 = write). It is acknowledged only when the code equals DEV_CODE (default 1010000, so 0xA0 writes and 0xA1 reads). Any other code is not acknowledged, and the block ignores the bus until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bytes clocked in with no START before them receive no acknowledge.
- R3: SDA is sampled on SCL rising edges. The block changes its SDA pull-down only while SCL is low.
- R4: As a receiver the block pulls SDA low during the 9th clock of each accepted byte. As a transmitter it releases SDA after 8 bits and samples the master's acknowledge on the 9th clock. After a master no-acknowledge it stops driving and waits in standby.
- R5: While the write-lock input is high, the device select and both address bytes are acknowledged, data bytes are not, the array is left unchanged and no programming interval starts.
- R6: A write sends the address high byte and then the low byte, and only the low ADDR_W-8 bits of the high byte are used. Successive data bytes go to successive addresses, and the low 5 address bits wrap inside the current 32-byte page.
- R7: A STOP after at least one acknowledged data byte starts a programming interval of PROG_CYCLES clocks. During that interval nothing is acknowledged and SDA is never pulled. Afterwards the block answers again.
- R8: Written data reaches the array only during the programming interval. A write that a START cuts off before any STOP changes nothing in the array.
- R9: A read with no address phase (current-address read) starts at the address that follows the last byte read or written. A random read is an address write followed by a repeated START and a read select.
- R10: A sequential read returns consecutive bytes while the master acknowledges, and it wraps from the last address to 0.
- R11: A START in the middle of any byte abandons that transfer and restarts device-code reception, leaving the address pointer as it was.
- R12: After reset SDA is not pulled and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| wrLock | input | 1 | Write lock; high refuses data bytes of writes |
| sdaPullLow | output | 1 | Open-drain enable; high pulls SDA to 0 |

## Verification
Two functions of this block can act on the same bus event. The first is the STOP that ends a write: it must both close the transfer and start the programming interval. The second is a START that arrives while a write is buffered or an address is half received: it must throw the buffer away and restart device-code reception. The bench provokes the first case by putting a START and device code right behind the STOP of a write. The select must go unanswered, and the array must afterwards hold the new data. It provokes the second case by cutting a write with a repeated START and by cutting the address low byte after four bits. It then checks that the array is unchanged, that no programming interval follows (an immediate select is answered), and that a current-address read returns the byte after the earlier pointer.

// File: rtl/eeprom_pkg.sv
`timescale 1ns/1ps
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDRHI,
    ST_ADDRLO,
    ST_WDATA,
    ST_RDATA,
    ST_PROG
  } phase_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic shiftIn;   // take one sampled bit into the receive byte
    logic hiLoad;    // hold upper address bits
    logic loLoad;    // load full pointer
    logic ptrInc;    // linear increment (read)
    logic pageInc;   // increment wrapping inside the page (write)
    logic bufWrite;  // store received byte in page buffer
    logic bufClear;  // drop buffered bytes
    logic commitEn;  // copy one buffer slot into the array
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_datapath.sv
`timescale 1ns/1ps
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [PAGE_W-1:0] commitIdx,
  output logic [7:0]        rxByte,
  output logic [7:0]        rdByte
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [HI_W-1:0]   hiHold;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        bufData  [PAGE_BYTES];
  logic              bufValid [PAGE_BYTES];
  logic [7:0]        mem      [DEPTH];
  logic [ADDR_W-1:0] commitAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      hiHold <= '0;
      ptr    <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (strobe.hiLoad)  hiHold <= rxByte[HI_W-1:0];
      if (strobe.loLoad)
        ptr <= {hiHold, rxByte};
      else if (strobe.ptrInc)
        ptr <= ptr + 1'b1;
      else if (strobe.pageInc)
        ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufData[g]  <= '0;
        bufValid[g] <= 1'b0;
      end else if (strobe.bufClear) begin
        bufValid[g] <= 1'b0;
      end else if (strobe.bufWrite && ptr[PAGE_W-1:0] == PAGE_W'(g)) begin
        bufData[g]  <= rxByte;
        bufValid[g] <= 1'b1;
      end
    end
  end

  assign commitAddr = {ptr[ADDR_W-1:PAGE_W], commitIdx};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.commitEn && bufValid[commitIdx]) begin
      mem[commitAddr] <= bufData[commitIdx];
    end
  end

  assign rdByte = mem[ptr];

endmodule

// File: rtl/eeprom_control.sv
`timescale 1ns/1ps
module eeprom_control
  import eeprom_pkg::*;
#(
  parameter int         PAGE_BYTES  = 32,
  parameter int         PROG_CYCLES = 1000000,
  parameter logic [6:0] DEV_CODE    = 7'b1010000,
  localparam int        PAGE_W      = $clog2(PAGE_BYTES),
  localparam int        CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wrLock,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        rdByte,
  output dpStrobe_t         strobe,
  output logic [PAGE_W-1:0] commitIdx,
  output logic              sdaBit,
  output logic              sdaPullLow,
  output logic              progBusy,
  output logic              stopSeen
);
  logic sclMeta, sclS, sclQ, sdaMeta, sdaS, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;
  phase_t           phase;
  logic [3:0]       bitCnt;
  logic             pull, ackGiven, masterAck, armed, loadPend, ackOk, rxPhase;
  logic             byteDone, ackSlot;
  logic [2:0]       txIdx;
  logic [CNT_W-1:0] progCnt;

  // two-flop synchronizers plus one history stage, idle-high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclQ} <= 3'b111;
      {sdaMeta, sdaS, sdaQ} <= 3'b111;
    end else begin
      {sclMeta, sclS, sclQ} <= {sclIn, sclMeta, sclS};
      {sdaMeta, sdaS, sdaQ} <= {sdaIn, sdaMeta, sdaS};
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign byteDone = sclFall && bitCnt == 4'd8;
  assign ackSlot  = sclFall && bitCnt == 4'd9;
  assign txIdx    = 3'(4'd7 - bitCnt);
  assign rxPhase  = phase inside {ST_DEVSEL, ST_ADDRHI, ST_ADDRLO, ST_WDATA};

  always_comb begin
    case (phase)
      ST_DEVSEL: ackOk = rxByte[7:1] == DEV_CODE;
      ST_ADDRHI,
      ST_ADDRLO: ackOk = 1'b1;
      ST_WDATA:  ackOk = !wrLock;
      default:   ackOk = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (phase == ST_PROG) begin
      strobe.commitEn = progCnt < CNT_W'(PAGE_BYTES);
    end else begin
      strobe.shiftIn  = sclRise && rxPhase && bitCnt < 4'd8;
      strobe.hiLoad   = byteDone && phase == ST_ADDRHI;
      strobe.loLoad   = byteDone && phase == ST_ADDRLO;
      strobe.bufWrite = byteDone && phase == ST_WDATA && !wrLock;
      strobe.pageInc  = byteDone && phase == ST_WDATA && !wrLock;
      strobe.ptrInc   = ackSlot && phase == ST_RDATA;
      strobe.bufClear = startDet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      bitCnt    <= '0;
      pull      <= 1'b0;
      ackGiven  <= 1'b0;
      masterAck <= 1'b0;
      armed     <= 1'b0;
      loadPend  <= 1'b0;
      progCnt   <= '0;
    end else if (phase == ST_PROG) begin
      pull <= 1'b0;
      if (progCnt == CNT_W'(PROG_CYCLES - 1)) begin
        phase   <= ST_IDLE;
        progCnt <= '0;
      end else begin
        progCnt <= progCnt + 1'b1;
      end
    end else if (startDet) begin
      phase    <= ST_DEVSEL;
      bitCnt   <= '0;
      pull     <= 1'b0;
      armed    <= 1'b0;
      loadPend <= 1'b0;
    end else if (stopDet) begin
      phase    <= (armed && phase == ST_WDATA) ? ST_PROG : ST_IDLE;
      bitCnt   <= '0;
      pull     <= 1'b0;
      armed    <= 1'b0;
      loadPend <= 1'b0;
      progCnt  <= '0;
    end else begin
      if (loadPend) begin
        pull     <= !rdByte[7];
        loadPend <= 1'b0;
      end
      if (sclRise && phase != ST_IDLE) begin
        bitCnt <= bitCnt + 1'b1;
        if (phase == ST_RDATA && bitCnt == 4'd8) masterAck <= !sdaS;
      end
      if (sclFall && phase != ST_IDLE) begin
        if (bitCnt == 4'd8) begin
          ackGiven <= ackOk;
          pull     <= (phase == ST_RDATA) ? 1'b0 : ackOk;
        end else if (bitCnt == 4'd9) begin
          pull   <= 1'b0;
          bitCnt <= '0;
          case (phase)
            ST_DEVSEL: begin
              if (!ackGiven) phase <= ST_IDLE;
              else if (rxByte[0]) begin
                phase    <= ST_RDATA;
                loadPend <= 1'b1;
              end else phase <= ST_ADDRHI;
            end
            ST_ADDRHI: phase <= ST_ADDRLO;
            ST_ADDRLO: phase <= ST_WDATA;
            ST_WDATA:  if (ackGiven) armed <= 1'b1;
            ST_RDATA: begin
              if (masterAck) loadPend <= 1'b1;
              else           phase    <= ST_IDLE;
            end
            default: phase <= ST_IDLE;
          endcase
        end else if (phase == ST_RDATA) begin
          pull <= !rdByte[txIdx];
        end
      end
    end
  end

  assign commitIdx  = progCnt[PAGE_W-1:0];
  assign sdaBit     = sdaS;
  assign sdaPullLow = pull;
  assign progBusy   = phase == ST_PROG;
  assign stopSeen   = stopDet;

endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_BYTES  = 32,
  parameter int         PROG_CYCLES = 1000000,
  parameter logic [6:0] DEV_CODE    = 7'b1010000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wrLock,
  output logic sdaPullLow
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  dpStrobe_t         strobes;
  logic [PAGE_W-1:0] commitIdx;
  logic [7:0]        rxByte, rdByte;
  logic              sdaBit, progBusy, stopSeen;

  eeprom_control #(
    .PAGE_BYTES (PAGE_BYTES),
    .PROG_CYCLES(PROG_CYCLES),
    .DEV_CODE   (DEV_CODE)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .wrLock    (wrLock),
    .rxByte    (rxByte),
    .rdByte    (rdByte),
    .strobe    (strobes),
    .commitIdx (commitIdx),
    .sdaBit    (sdaBit),
    .sdaPullLow(sdaPullLow),
    .progBusy  (progBusy),
    .stopSeen  (stopSeen)
  );

  eeprom_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobes),
    .sdaBit   (sdaBit),
    .commitIdx(commitIdx),
    .rxByte   (rxByte),
    .rdByte   (rdByte)
  );

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullLow,
  input logic busy,
  input logic stopDet,
  input logic commitEn
);

  // R7: the bus is left alone for the whole programming interval
  assert_quiet_in_prog_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullLow);

  // R7: the programming interval is entered only from a STOP
  assert_prog_after_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet));

  // R8: array updates happen only inside the programming interval
  assert_commit_in_prog_R8: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> busy);

  // R3: pull-down does not move while SCL has been high for a while
  assert_steady_scl_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sclIn, 2) && $past(sclIn, 3) && $past(sclIn, 4))
      |-> $stable(sdaPullLow));

  // R2: a STOP leaves SDA released
  assert_release_after_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaPullLow);

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaPullLow(sdaPullLow),
  .busy      (progBusy),
  .stopDet   (stopSeen),
  .commitEn  (strobes.commitEn)
);

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
  localparam int PROG  = 300;
  localparam int Q     = 10;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sclM, sdaM, wrLock, pull;
  wire  sdaLine = sdaM & ~pull;

  int checks = 0;
  int errors = 0;
  int monErr = 0;
  bit blindExp = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic [4:0] sclHist = '0;
  logic       prevPull = 1'b0;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .wrLock(wrLock), .sdaPullLow(pull)
  );

  // per-clock reference: pull-down frozen while SCL is steadily high (R3),
  // and never active while a programming interval is expected (R7)
  always @(negedge clk) begin
    if (rstN) begin
      if (&sclHist && sclM && pull !== prevPull) monErr++;
      if (blindExp && pull !== 1'b0) monErr++;
    end
    sclHist  <= {sclHist[3:0], sclM};
    prevPull <= pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sclM = 1'b0; waitQ(); sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sclM = 1'b0; waitQ(); sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sclM = 1'b0; waitQ(); sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    sclM = 1'b0; waitQ(); sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ(); got = (sdaLine == 1'b0); waitQ();
    chk(got == expAck, req, int'(got), int'(expAck));
  endtask

  task automatic getByte(input bit mAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sclM = 1'b0; waitQ(); sdaM = 1'b1; waitQ();
      sclM = 1'b1; waitQ(); v[i] = sdaLine; waitQ();
    end
    sclM = 1'b0; waitQ(); sdaM = !mAck; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic readAt(input int addr, input int n, input string req);
    logic [7:0] v;
    startCond();
    sendByte(8'hA0, 1'b1, req);
    sendByte(8'(addr >> 8) | 8'hF8, 1'b1, req);
    sendByte(8'(addr), 1'b1, req);
    startCond();
    sendByte(8'hA1, 1'b1, req);
    for (int i = 0; i < n; i++) begin
      getByte(i < n - 1, v);
      chk(v === mdl[(addr + i) % DEPTH], req, int'(v), int'(mdl[(addr + i) % DEPTH]));
    end
    stopCond();
  endtask

  task automatic curRead(input int addr, input int n, input string req);
    logic [7:0] v;
    startCond();
    sendByte(8'hA1, 1'b1, req);
    for (int i = 0; i < n; i++) begin
      getByte(i < n - 1, v);
      chk(v === mdl[(addr + i) % DEPTH], req, int'(v), int'(mdl[(addr + i) % DEPTH]));
    end
    sclM = 1'b0; waitQ(); waitQ();
    chk(pull == 1'b0, "R4 released after no-ack", int'(pull), 0);
    stopCond();
  endtask

  task automatic memWrite(input int addr, input int n, input logic [7:0] first,
                          input bit probe, input string req);
    int a;
    startCond();
    sendByte(8'hA0, 1'b1, req);
    sendByte(8'(addr >> 8) | 8'hF8, 1'b1, req);
    sendByte(8'(addr), 1'b1, req);
    for (int i = 0; i < n; i++) begin
      sendByte(first + 8'(i), 1'b1, req);
      a = (addr & ~31) | ((addr + i) & 31);
      mdl[a] = first + 8'(i);
    end
    stopCond();
    blindExp = 1'b1;
    if (probe) begin
      startCond();
      sendByte(8'hA0, 1'b0, "R7 select during programming");
      stopCond();
    end
    repeat (PROG + 60) @(negedge clk);
    blindExp = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    sclM = 1'b1; sdaM = 1'b1; wrLock = 1'b0; rstN = 1'b0;
    repeat (10) @(negedge clk);
    chk(pull == 1'b0, "R12 reset pull", int'(pull), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R12: pointer starts at 0
    curRead(0, 1, "R12 read after reset");

    // R1: wrong device code, then bytes without START stay ignored
    startCond();
    sendByte(8'hA2, 1'b0, "R1 wrong code");
    sendByte(8'hA0, 1'b0, "R1 ignored until START");
    stopCond();

    // R2: no START before the select
    sendByte(8'hA0, 1'b0, "R2 missing START");
    stopCond();

    // R7: byte write, probe during programming, readback
    memWrite(32'h123, 1, 8'hA5, 1'b1, "R7 byte write");
    readAt(32'h123, 1, "R7 readback");

    memWrite(32'h124, 2, 8'h61, 1'b0, "R9 setup");

    // R6: page write wrapping inside the page
    memWrite(32'h03E, 4, 8'h30, 1'b0, "R6 page write");
    readAt(32'h020, 2, "R6 wrapped bytes");
    readAt(32'h03E, 3, "R6 page tail");

    // R5: write lock
    wrLock = 1'b1;
    startCond();
    sendByte(8'hA0, 1'b1, "R5 select acked");
    sendByte(8'hF9, 1'b1, "R5 high addr acked");
    sendByte(8'h00, 1'b1, "R5 low addr acked");
    sendByte(8'h5A, 1'b0, "R5 data refused");
    sendByte(8'h5B, 1'b0, "R5 data refused");
    stopCond();
    startCond();
    sendByte(8'hA0, 1'b1, "R5 no programming interval");
    stopCond();
    wrLock = 1'b0;
    readAt(32'h100, 2, "R5 array unchanged");

    // R9: random read then current-address reads
    readAt(32'h123, 1, "R9 random read");
    curRead(32'h124, 2, "R9 current read");

    // R10: sequential read wraps to 0
    memWrite(32'h7FF, 1, 8'h5C, 1'b0, "R10 setup");
    memWrite(32'h000, 1, 8'h11, 1'b0, "R10 setup");
    readAt(32'h7FF, 3, "R10 wrap");

    // R8: write cut by a repeated START commits nothing
    startCond();
    sendByte(8'hA0, 1'b1, "R8 select");
    sendByte(8'hFA, 1'b1, "R8 high addr");
    sendByte(8'h00, 1'b1, "R8 low addr");
    sendByte(8'h77, 1'b1, "R8 data");
    startCond();
    sendByte(8'hA1, 1'b1, "R8 read select");
    getByte(1'b0, v);
    chk(v === mdl[32'h201], "R8 pointer after data", int'(v), int'(mdl[32'h201]));
    stopCond();
    startCond();
    sendByte(8'hA0, 1'b1, "R8 no programming after abort");
    stopCond();
    readAt(32'h200, 1, "R8 array unchanged");

    // R11: START in the middle of the address low byte
    readAt(32'h123, 1, "R11 set pointer");
    startCond();
    sendByte(8'hA0, 1'b1, "R11 select");
    sendByte(8'hF8, 1'b1, "R11 high addr");
    for (int i = 0; i < 4; i++) putBit(1'b1);
    curRead(32'h124, 1, "R11 restart");

    chk(monErr == 0, "R3 R7 per-clock drive monitor", monErr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule